// File: doc/BRIEF.md
# Effective Address Generator

This unit resolves where the operand of an 8-bit processor instruction lives. The caller presents an addressing-mode code, the one or two operand bytes that follow the opcode, and the current X and Y index registers, then pulses `start`. The unit answers with a 16-bit effective address, or with a marker saying that the operand is an immediate byte or that the instruction has no memory operand at all. For relative mode it returns the sign-extended branch displacement, which the branch logic adds to the program counter.

The modes that compute their answer from the inputs alone (zero page, indexed zero page, absolute, indexed absolute, relative, immediate, implied) finish one cycle after `start`. The three pointer modes (indirect, X-indexed indirect, Y-indirect) fetch a two-byte little-endian pointer through a synchronous byte-read port, whose data returns in the cycle after the request. They finish four cycles after `start`. Pointer fetches from zero page wrap within zero page. Opcode decoding and cycle penalties for page crossings belong to the surrounding core.

Top module: `eff_addr_gen`

## Requirements
- R1: After reset, `done`, `busy` and `mem_rd_en` are low.
- R2: Mode code 0 (implied or accumulator) gives kind 2 (no memory operand). `done` rises one cycle after `start` is accepted. No memory read is issued.
- R3: Mode code 1 (immediate) gives kind 1 and returns `opnd_lo` on `imm_data`, with `done` one cycle after `start`.
- R4: Mode codes 2, 3 and 4 (zero page, zero page plus X, zero page plus Y) give kind 0. The effective address is `{8'h00, (opnd_lo + index) mod 256}`, where the index is 0, X or Y. It is ready one cycle after `start`.
- R5: Mode codes 6, 7 and 8 (absolute, absolute plus X, absolute plus Y) give kind 0. The effective address is `{opnd_hi, opnd_lo}` plus the zero-extended index, modulo 65536. It is ready one cycle after `start`.
- R6: Mode code 5 (relative) gives kind 3. `ea` carries `opnd_lo` sign-extended to 16 bits, one cycle after `start`.
- R7: Mode code 9 (indirect) reads the low pointer byte at `{opnd_hi, opnd_lo}` and the high byte at that address plus 1, modulo 65536. The effective address is the resulting little-endian word, kind 0, and `done` comes four cycles after `start`.
- R8: Mode code 10 (X-indexed indirect) reads the pointer from zero page at p = (`opnd_lo` + X) mod 256 and at (p + 1) mod 256. The effective address is that word.
- R9: Mode code 11 (Y-indirect) reads the pointer from zero page at `opnd_lo` and at (`opnd_lo` + 1) mod 256. It then adds Y, zero-extended, modulo 65536.
- R10: `done` is a one-cycle pulse. `busy` is high while a pointer fetch is in progress. A `start` seen while `busy` is high is ignored: the running result, its timing and the number of `done` pulses do not change.
- R11: Each pointer mode makes exactly two read requests on consecutive cycles, low byte address first. Other modes make none.
- R12: Undefined mode codes 12 to 15 behave like mode code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin resolving an operand; sampled when `busy` is low |
| mode | input | 4 | Addressing-mode code |
| opnd_lo | input | 8 | First operand byte |
| opnd_hi | input | 8 | Second operand byte |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| mem_rd_en | output | 1 | Byte read request |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after the request |
| busy | output | 1 | Pointer fetch in progress |
| done | output | 1 | Result valid pulse |
| kind | output | 2 | 0 address, 1 immediate, 2 none, 3 relative |
| ea | output | 16 | Effective address or sign-extended displacement, held until the next result |
| imm_data | output | 8 | Immediate operand byte |

## Verification
The direct modes must raise `done` in the first cycle after the accepting edge. The pointer modes must raise it in the fourth, after one request cycle for each pointer byte and one cycle for the high byte's data to return. The bench counts falling edges from the accepting edge until `done` appears. It requires exactly that count for each mode and checks the outputs at that same falling edge. It also checks that `done` is low one cycle later. Read addresses are recorded at each rising edge on which a request is made, and compared with the two expected pointer locations in order.

// File: rtl/eag_pkg.sv
package eag_pkg;

   // Addressing-mode codes presented on the mode input
   localparam logic [3:0] MD_IMPL = 4'd0;
   localparam logic [3:0] MD_IMM  = 4'd1;
   localparam logic [3:0] MD_ZPG  = 4'd2;
   localparam logic [3:0] MD_ZPX  = 4'd3;
   localparam logic [3:0] MD_ZPY  = 4'd4;
   localparam logic [3:0] MD_REL  = 4'd5;
   localparam logic [3:0] MD_ABS  = 4'd6;
   localparam logic [3:0] MD_ABX  = 4'd7;
   localparam logic [3:0] MD_ABY  = 4'd8;
   localparam logic [3:0] MD_IND  = 4'd9;
   localparam logic [3:0] MD_XIN  = 4'd10;
   localparam logic [3:0] MD_INY  = 4'd11;

   // What the ea output means
   typedef enum logic [1:0] {
      KD_ADDR = 2'd0,
      KD_IMM  = 2'd1,
      KD_NONE = 2'd2,
      KD_REL  = 2'd3
   } ea_kind_t;

   // Pointer fetch sequencer states
   typedef enum logic [1:0] {
      PS_IDLE   = 2'd0,
      PS_LO     = 2'd1,
      PS_HI     = 2'd2,
      PS_SETTLE = 2'd3
   } pstate_t;

   function automatic logic is_ptr_mode(input logic [3:0] m);
      return (m == MD_IND) || (m == MD_XIN) || (m == MD_INY);
   endfunction

endpackage

// File: rtl/eag_direct.sv
module eag_direct
   import eag_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic [3:0]        mode,
   input  logic [DATA_W-1:0] opnd_lo,
   input  logic [DATA_W-1:0] opnd_hi,
   input  logic [DATA_W-1:0] idx_x,
   input  logic [DATA_W-1:0] idx_y,
   output logic [ADDR_W-1:0] ea,
   output ea_kind_t          kind
);
   localparam int HIGH_W = ADDR_W - DATA_W;

   logic [DATA_W-1:0] idx_sel;
   logic [DATA_W-1:0] zp_sum;
   logic [ADDR_W-1:0] abs_base;
   logic [ADDR_W-1:0] abs_sum;
   logic [ADDR_W-1:0] zp_ea;
   logic [ADDR_W-1:0] rel_ea;

   always_comb begin
      unique case (mode)
         MD_ZPX, MD_ABX: idx_sel = idx_x;
         MD_ZPY, MD_ABY: idx_sel = idx_y;
         default:        idx_sel = '0;
      endcase
   end

   // zero page sum wraps inside the low byte
   assign zp_sum   = opnd_lo + idx_sel;
   assign zp_ea    = {{HIGH_W{1'b0}}, zp_sum};
   assign abs_base = {opnd_hi, opnd_lo};
   assign abs_sum  = abs_base + {{HIGH_W{1'b0}}, idx_sel};
   assign rel_ea   = {{HIGH_W{opnd_lo[DATA_W-1]}}, opnd_lo};

   always_comb begin
      ea   = '0;
      kind = KD_NONE;
      case (mode)
         MD_IMM: begin
            kind = KD_IMM;
         end
         MD_ZPG, MD_ZPX, MD_ZPY: begin
            kind = KD_ADDR;
            ea   = zp_ea;
         end
         MD_ABS, MD_ABX, MD_ABY: begin
            kind = KD_ADDR;
            ea   = abs_sum;
         end
         MD_REL: begin
            kind = KD_REL;
            ea   = rel_ea;
         end
         default: begin
            kind = KD_NONE;
            ea   = '0;
         end
      endcase
   end

endmodule

// File: rtl/eag_ptr_fetch.sv
module eag_ptr_fetch
   import eag_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter bit ZP_PTR_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  logic [3:0]        mode,
   input  logic [DATA_W-1:0] opnd_lo,
   input  logic [DATA_W-1:0] opnd_hi,
   input  logic [DATA_W-1:0] idx_x,
   input  logic [DATA_W-1:0] idx_y,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              busy,
   output logic              last,
   output logic [ADDR_W-1:0] ea_now
);
   localparam int HIGH_W = ADDR_W - DATA_W;

   pstate_t           st_q;
   logic [ADDR_W-1:0] ptr_q;
   logic              zp_q;
   logic [DATA_W-1:0] lo_q;
   logic [DATA_W-1:0] add_q;

   logic [ADDR_W-1:0] base_addr;
   logic [DATA_W-1:0] xin_ptr;
   logic [ADDR_W-1:0] ptr_next;

   assign xin_ptr = opnd_lo + idx_x;

   always_comb begin
      unique case (mode)
         MD_XIN:  base_addr = {{HIGH_W{1'b0}}, xin_ptr};
         MD_INY:  base_addr = {{HIGH_W{1'b0}}, opnd_lo};
         default: base_addr = {opnd_hi, opnd_lo};
      endcase
   end

   // Address of the pointer's high byte
   generate
      if (ZP_PTR_WRAP) begin : g_zp_wrap
         logic [DATA_W-1:0] zp_inc;
         assign zp_inc   = ptr_q[DATA_W-1:0] + DATA_W'(1);
         assign ptr_next = zp_q ? {{HIGH_W{1'b0}}, zp_inc} : ptr_q + ADDR_W'(1);
      end else begin : g_zp_carry
         assign ptr_next = ptr_q + ADDR_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= PS_IDLE;
         ptr_q <= '0;
         zp_q  <= 1'b0;
         lo_q  <= '0;
         add_q <= '0;
      end else begin
         case (st_q)
            PS_IDLE: begin
               if (launch) begin
                  st_q  <= PS_LO;
                  ptr_q <= base_addr;
                  zp_q  <= (mode != MD_IND);
                  add_q <= (mode == MD_INY) ? idx_y : '0;
               end
            end
            PS_LO:   st_q <= PS_HI;
            PS_HI: begin
               lo_q <= mem_rdata;
               st_q <= PS_SETTLE;
            end
            default: st_q <= PS_IDLE;
         endcase
      end
   end

   assign mem_rd_en = (st_q == PS_LO) || (st_q == PS_HI);
   assign mem_addr  = (st_q == PS_HI) ? ptr_next : ptr_q;
   assign busy      = (st_q != PS_IDLE);
   assign last      = (st_q == PS_SETTLE);
   assign ea_now    = {mem_rdata, lo_q} + {{HIGH_W{1'b0}}, add_q};

endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
   import eag_pkg::*;
#(
   parameter int ADDR_W      = 16,
   parameter int DATA_W      = 8,
   parameter bit ZP_PTR_WRAP = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [3:0]        mode,
   input  logic [DATA_W-1:0] opnd_lo,
   input  logic [DATA_W-1:0] opnd_hi,
   input  logic [DATA_W-1:0] idx_x,
   input  logic [DATA_W-1:0] idx_y,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy,
   output logic              done,
   output logic [1:0]        kind,
   output logic [ADDR_W-1:0] ea,
   output logic [DATA_W-1:0] imm_data
);
   generate
      if (ADDR_W != 2 * DATA_W) begin : g_bad_width
         $error("eff_addr_gen: ADDR_W must be twice DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("eff_addr_gen: DATA_W too small");
      end
   endgenerate

   logic              accept;
   logic              go_ptr;
   logic              go_direct;
   logic [ADDR_W-1:0] dir_ea;
   ea_kind_t          dir_kind;
   logic              ptr_busy;
   logic              ptr_last;
   logic [ADDR_W-1:0] ptr_ea;

   logic              done_q;
   ea_kind_t          kind_q;
   logic [ADDR_W-1:0] ea_q;
   logic [DATA_W-1:0] imm_q;

   assign accept    = start && !ptr_busy;
   assign go_ptr    = accept && is_ptr_mode(mode);
   assign go_direct = accept && !is_ptr_mode(mode);

   eag_direct #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_direct (
      .mode    (mode),
      .opnd_lo (opnd_lo),
      .opnd_hi (opnd_hi),
      .idx_x   (idx_x),
      .idx_y   (idx_y),
      .ea      (dir_ea),
      .kind    (dir_kind)
   );

   eag_ptr_fetch #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .ZP_PTR_WRAP (ZP_PTR_WRAP)
   ) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .launch    (go_ptr),
      .mode      (mode),
      .opnd_lo   (opnd_lo),
      .opnd_hi   (opnd_hi),
      .idx_x     (idx_x),
      .idx_y     (idx_y),
      .mem_rdata (mem_rdata),
      .mem_rd_en (mem_rd_en),
      .mem_addr  (mem_addr),
      .busy      (ptr_busy),
      .last      (ptr_last),
      .ea_now    (ptr_ea)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         kind_q <= KD_NONE;
         ea_q   <= '0;
         imm_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (ptr_last) begin
            done_q <= 1'b1;
            kind_q <= KD_ADDR;
            ea_q   <= ptr_ea;
         end else if (go_direct) begin
            done_q <= 1'b1;
            kind_q <= dir_kind;
            ea_q   <= dir_ea;
            imm_q  <= opnd_lo;
         end
      end
   end

   assign busy     = ptr_busy;
   assign done     = done_q;
   assign kind     = kind_q;
   assign ea       = ea_q;
   assign imm_data = imm_q;

endmodule

// File: rtl/eag_checker.sv
module eag_checker
   import eag_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [3:0]        mode,
   input logic [DATA_W-1:0] opnd_lo,
   input logic              busy,
   input logic              done,
   input logic [1:0]        kind,
   input logic [DATA_W-1:0] imm_data,
   input logic              mem_rd_en
);
   logic direct_go;
   assign direct_go = start && !busy && !is_ptr_mode(mode);

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10

   AST_READ_IN_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> busy); // R11

   AST_READ_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_rd_en) |=> mem_rd_en); // R11

   AST_READ_END: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd_en && $past(mem_rd_en)) |=> !mem_rd_en); // R11

   AST_DIRECT_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      direct_go |=> done); // R2

   AST_IMM_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (direct_go && mode == MD_IMM) |=>
         (kind == KD_IMM && imm_data == $past(opnd_lo))); // R3

endmodule

bind eff_addr_gen eag_checker #(.DATA_W(DATA_W)) u_eag_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .mode      (mode),
   .opnd_lo   (opnd_lo),
   .busy      (busy),
   .done      (done),
   .kind      (kind),
   .imm_data  (imm_data),
   .mem_rd_en (mem_rd_en)
);

// File: tb/eff_addr_gen_test.sv
module eff_addr_gen_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  mode_i = '0;
   logic [7:0]  lo_i = '0, hi_i = '0, x_i = '0, y_i = '0;
   logic        mem_rd_en;
   logic [15:0] mem_addr;
   logic [7:0]  mem_rdata = '0;
   logic        busy, done;
   logic [1:0]  kind;
   logic [15:0] ea;
   logic [7:0]  imm_data;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   int          rd_n = 0;
   logic [15:0] rd_a0 = '0, rd_a1 = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   eff_addr_gen uut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode_i),
      .opnd_lo(lo_i), .opnd_hi(hi_i), .idx_x(x_i), .idx_y(y_i),
      .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .busy(busy), .done(done), .kind(kind), .ea(ea), .imm_data(imm_data)
   );

   function automatic logic [7:0] mem_byte(input logic [15:0] a);
      return a[7:0] ^ (a[15:8] * 8'd7) ^ 8'h3C;
   endfunction

   // synchronous byte memory model and read recorder
   always @(posedge clk) begin
      if (mem_rd_en) begin
         mem_rdata <= mem_byte(mem_addr);
         if (rd_n == 0) rd_a0 = mem_addr;
         else if (rd_n == 1) rd_a1 = mem_addr;
         rd_n = rd_n + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_op(input logic [3:0] m, input logic [7:0] lo, hi, x, y,
                         input bit poke);
      logic [1:0]  e_kind;
      logic [15:0] e_ea, a0, a1;
      logic [7:0]  p;
      int          e_lat, e_reads, cnt;
      bit          got;
      string       req;
      e_ea = '0; a0 = '0; a1 = '0; e_lat = 1; e_reads = 0; e_kind = 2'd0;
      case (m)
         4'd1: begin e_kind = 2'd1; req = "R3"; end
         4'd2: begin e_ea = {8'h00, lo}; req = "R4"; end
         4'd3: begin p = lo + x; e_ea = {8'h00, p}; req = "R4"; end
         4'd4: begin p = lo + y; e_ea = {8'h00, p}; req = "R4"; end
         4'd5: begin e_kind = 2'd3; e_ea = {{8{lo[7]}}, lo}; req = "R6"; end
         4'd6: begin e_ea = {hi, lo}; req = "R5"; end
         4'd7: begin e_ea = {hi, lo} + {8'h00, x}; req = "R5"; end
         4'd8: begin e_ea = {hi, lo} + {8'h00, y}; req = "R5"; end
         4'd9: begin
            a0 = {hi, lo}; a1 = a0 + 16'd1; req = "R7";
         end
         4'd10: begin
            p = lo + x; a0 = {8'h00, p}; p = p + 8'd1; a1 = {8'h00, p}; req = "R8";
         end
         4'd11: begin
            a0 = {8'h00, lo}; p = lo + 8'd1; a1 = {8'h00, p}; req = "R9";
         end
         4'd0: begin e_kind = 2'd2; req = "R2"; end
         default: begin e_kind = 2'd2; req = "R12"; end
      endcase
      if (m >= 4'd9 && m <= 4'd11) begin
         e_lat = 4; e_reads = 2;
         e_ea = {mem_byte(a1), mem_byte(a0)} + ((m == 4'd11) ? {8'h00, y} : 16'h0);
      end

      @(negedge clk);
      mode_i = m; lo_i = lo; hi_i = hi; x_i = x; y_i = y;
      start = 1'b1; rd_n = 0;
      @(posedge clk);
      cnt = 0; got = 1'b0;
      while (cnt < 8 && !got) begin
         @(negedge clk);
         cnt++;
         if (done) got = 1'b1;
         if (cnt == 1) begin
            start = 1'b0;
            if (poke) begin
               chk(busy == 1'b1, "R10", "busy during fetch", 32'(busy), 32'd1);
               start = 1'b1; mode_i = 4'd1; lo_i = ~lo;
            end
         end else if (cnt == 2) begin
            start = 1'b0;
         end
      end
      chk(got && cnt == e_lat, req, "done latency", 32'(cnt), 32'(e_lat));
      chk(kind == e_kind, req, "kind", 32'(kind), 32'(e_kind));
      if (e_kind == 2'd0 || e_kind == 2'd3)
         chk(ea == e_ea, req, "ea", 32'(ea), 32'(e_ea));
      if (e_kind == 2'd1)
         chk(imm_data == lo, req, "imm_data", 32'(imm_data), 32'(lo));
      chk(rd_n == e_reads, "R11", "read count", 32'(rd_n), 32'(e_reads));
      if (e_reads == 2) begin
         chk(rd_a0 == a0, req, "low byte address", 32'(rd_a0), 32'(a0));
         chk(rd_a1 == a1, req, "high byte address", 32'(rd_a1), 32'(a1));
      end
      @(negedge clk);
      chk(done == 1'b0, "R10", "done pulse width", 32'(done), 32'd0);
      if (poke) begin
         @(negedge clk);
         chk(done == 1'b0 && rd_n == e_reads, "R10", "ignored start effect",
             {31'd0, done}, 32'd0);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(done == 1'b0 && busy == 1'b0 && mem_rd_en == 1'b0, "R1", "reset outputs",
          {29'd0, done, busy, mem_rd_en}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R1", "idle after reset",
          {30'd0, done, busy}, 32'd0);

      // directed corners
      run_op(4'd0,  8'h12, 8'h34, 8'h00, 8'h00, 1'b0); // R2
      run_op(4'd1,  8'hA7, 8'h00, 8'h00, 8'h00, 1'b0); // R3
      run_op(4'd3,  8'hF0, 8'h99, 8'h20, 8'h00, 1'b0); // R4 wrap to 0x0010
      run_op(4'd4,  8'hFF, 8'h99, 8'h00, 8'h01, 1'b0); // R4 wrap to 0x0000
      run_op(4'd7,  8'hFF, 8'hFF, 8'h01, 8'h00, 1'b0); // R5 wrap to 0x0000
      run_op(4'd8,  8'hF0, 8'h12, 8'h00, 8'h20, 1'b0); // R5 page carry
      run_op(4'd5,  8'h80, 8'h00, 8'h00, 8'h00, 1'b0); // R6 negative
      run_op(4'd5,  8'h7F, 8'h00, 8'h00, 8'h00, 1'b0); // R6 positive
      run_op(4'd9,  8'hFF, 8'hFF, 8'h00, 8'h00, 1'b0); // R7 16-bit wrap
      run_op(4'd9,  8'hFF, 8'h02, 8'h00, 8'h00, 1'b0); // R7 page carry
      run_op(4'd10, 8'hFE, 8'h00, 8'h01, 8'h00, 1'b0); // R8 pointer at 0xFF
      run_op(4'd10, 8'h80, 8'h00, 8'h80, 8'h00, 1'b0); // R8 index wrap
      run_op(4'd11, 8'hFF, 8'h00, 8'h00, 8'hFF, 1'b0); // R9 pointer at 0xFF
      run_op(4'd13, 8'h55, 8'h66, 8'h00, 8'h00, 1'b0); // R12
      run_op(4'd15, 8'h55, 8'h66, 8'h00, 8'h00, 1'b0); // R12
      run_op(4'd11, 8'h40, 8'h00, 8'h00, 8'h33, 1'b1); // R10 start while busy
      run_op(4'd9,  8'h10, 8'h20, 8'h00, 8'h00, 1'b1); // R10 start while busy

      // constrained random
      for (int i = 0; i < 300; i++) begin
         logic [3:0] m;
         m = 4'($urandom % 16);
         run_op(m, 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                (m >= 4'd9 && m <= 4'd11) && ($urandom % 8 == 0));
      end
      finish_run();
   end

endmodule